// File: doc/BRIEF.md
# Transmit Source Address Inserter

This block sits in a byte-wide transmit stream between the user logic and the frame builder. When insertion is on, it overwrites the six-byte source address of each frame with one of five station addresses: a primary one and four supplementary ones. A 3-bit select code picks the address. Every other byte passes through unchanged. The valid, start-of-frame and end-of-frame markers and the ready backpressure go through untouched, so the block adds no latency and never drops or repeats a beat.

The insertion enable, the select code and the chosen address are captured when the first beat of a frame is accepted. Changes to these inputs during a frame therefore act only from the next frame. Each station address arrives as a 32-bit low word and a 16-bit high word. Byte 0 of the address is bits 7:0 of the low word and is the first address byte sent.

Top module: `tx_srcaddr_ins`

## Requirements
- R1: `s_ready` equals `m_ready`. `m_valid`, `m_sop` and `m_eop` equal `s_valid`, `s_sop` and `s_eop` in every cycle.
- R2: A frame whose start beat was accepted with `ins_en` low leaves the block with every byte unchanged.
- R3: In a frame accepted with `ins_en` high, the bytes at offsets 6 to 11 (the start beat is offset 0) become address bytes 0 to 5 in that order. Address byte k is bits 8k+7:8k of {high word, low word}.
- R4: Select code 3'b000 picks the primary address (`prim_lo`, `prim_hi`).
- R5: Select codes 3'b100, 3'b101, 3'b110 and 3'b111 pick supplementary address 0, 1, 2 and 3. Slot n is `sup_lo[32n+31:32n]` and `sup_hi[16n+15:16n]`.
- R6: The unused select codes 3'b001, 3'b010 and 3'b011 pick the primary address.
- R7: Bytes at offsets 0 to 5, and at offset 12 or later, pass unchanged even with insertion on.
- R8: The enable, the select code and both words of the chosen address are sampled when the start beat is accepted. Changing them later in the frame has no effect on that frame.
- R9: A stalled beat (valid high, ready low) does not advance the byte offset. Every accepted input beat appears once at the output, in order.
- R10: After reset, and after the end beat of a frame, beats that have no start marker pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_en | input | 1 | Source address insertion enable |
| addr_sel | input | 3 | Station address select code |
| prim_lo | input | 32 | Primary address, low word |
| prim_hi | input | 16 | Primary address, high word |
| sup_lo | input | 128 | Four supplementary low words, slot n at bits 32n+31:32n |
| sup_hi | input | 64 | Four supplementary high words, slot n at bits 16n+15:16n |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high |
| s_data | input | 8 | Input byte |
| s_sop | input | 1 | Input start of frame |
| s_eop | input | 1 | Input end of frame |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 8 | Output byte |
| m_sop | output | 1 | Output start of frame |
| m_eop | output | 1 | Output end of frame |

## Verification
The bench walks all eight select codes, including the three unused ones. If the decode were wrong, a supplementary slot or the primary address would appear in place of the correct one. It sends frames of length 1, 8, 12 and longer. Short frames end inside the address field, and a counter that does not clear or saturate correctly would corrupt the next frame or the payload after byte 11. It flips the enable, the select code and the address words after the start beat, which catches a design that reads them live instead of holding them. It also runs long stretches with random downstream stalls, which catch an offset that moves on unaccepted beats and so shifts the address by one byte.

// File: rtl/sa_ins_pkg.sv
package sa_ins_pkg;
  localparam int BYTE_W   = 8;
  localparam int SA_OFS   = 6;
  localparam int SA_BYTES = 6;
  localparam int LO_W     = 32;
  localparam int HI_W     = 16;
  localparam int ADDR_W   = LO_W + HI_W;
  localparam int SEL_W    = 3;

  // address byte k of a 48-bit station address, byte 0 = low bits
  function automatic logic [BYTE_W-1:0] addr_byte(input logic [ADDR_W-1:0] a,
                                                  input int unsigned k);
    return a[k*BYTE_W +: BYTE_W];
  endfunction

  // codes with the top bit set name a supplementary slot
  function automatic logic sel_is_sup(input logic [SEL_W-1:0] sel);
    return sel[SEL_W-1];
  endfunction
endpackage

// File: rtl/sa_ins_select.sv
module sa_ins_select
  import sa_ins_pkg::*;
#(
  parameter int NUM_SUP = 4
) (
  input  logic [SEL_W-1:0]         sel,
  input  logic [LO_W-1:0]          prim_lo,
  input  logic [HI_W-1:0]          prim_hi,
  input  logic [NUM_SUP*LO_W-1:0]  sup_lo,
  input  logic [NUM_SUP*HI_W-1:0]  sup_hi,
  output logic [ADDR_W-1:0]        addr_o
);
  localparam int IDX_W = SEL_W - 1;

  logic [ADDR_W-1:0] sup_addr [NUM_SUP];
  logic [IDX_W-1:0]  slot;

  for (genvar g = 0; g < NUM_SUP; g++) begin : g_slot
    assign sup_addr[g] = {sup_hi[g*HI_W +: HI_W], sup_lo[g*LO_W +: LO_W]};
  end

  assign slot = sel[IDX_W-1:0];

  always_comb begin
    if (sel_is_sup(sel)) addr_o = sup_addr[slot];
    else                 addr_o = {prim_hi, prim_lo};
  end
endmodule

// File: rtl/sa_ins_track.sv
module sa_ins_track
  import sa_ins_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              sop,
  input  logic              eop,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [OFF_W-1:0]  off_o,
  output logic              win_o,
  output logic              frm_en_o,
  output logic [ADDR_W-1:0] frm_addr_o
);
  localparam logic [OFF_W-1:0] OFF_FIRST = OFF_W'(SA_OFS);
  localparam logic [OFF_W-1:0] OFF_END   = OFF_W'(SA_OFS + SA_BYTES);

  logic [OFF_W-1:0]  cnt_q;
  logic              frm_en_q;
  logic [ADDR_W-1:0] frm_addr_q;

  assign off_o      = sop ? '0 : cnt_q;
  assign win_o      = (off_o >= OFF_FIRST) && (off_o < OFF_END);
  assign frm_en_o   = frm_en_q;
  assign frm_addr_o = frm_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      frm_en_q   <= 1'b0;
      frm_addr_q <= '0;
    end else if (fire) begin
      if (eop)                  cnt_q <= '0;
      else if (sop)             cnt_q <= OFF_W'(1);
      else if (cnt_q != OFF_END) cnt_q <= cnt_q + OFF_W'(1);
      if (eop)      frm_en_q <= 1'b0;
      else if (sop) frm_en_q <= en_i;
      if (sop) frm_addr_q <= addr_i;
    end
  end

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(cnt_q));
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sop && !eop) |=> (cnt_q == OFF_W'(1)));
  p_cfg_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && sop) |=> $stable(frm_addr_q));
  p_end_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && eop) |=> (cnt_q == '0 && !frm_en_q));
  p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !sop && !eop && cnt_q == OFF_END) |=> (cnt_q == OFF_END));
endmodule

// File: rtl/sa_ins_replace.sv
module sa_ins_replace
  import sa_ins_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic [BYTE_W-1:0] din,
  input  logic [OFF_W-1:0]  off,
  input  logic              win,
  input  logic              frm_en,
  input  logic [ADDR_W-1:0] frm_addr,
  output logic [BYTE_W-1:0] dout
);
  int unsigned k;

  always_comb begin
    k    = int'(off) - SA_OFS;
    dout = din;
    if (win && frm_en) dout = addr_byte(frm_addr, k);
  end
endmodule

// File: rtl/tx_srcaddr_ins.sv
module tx_srcaddr_ins
  import sa_ins_pkg::*;
#(
  parameter int NUM_SUP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_en,
  input  logic [SEL_W-1:0]         addr_sel,
  input  logic [LO_W-1:0]          prim_lo,
  input  logic [HI_W-1:0]          prim_hi,
  input  logic [NUM_SUP*LO_W-1:0]  sup_lo,
  input  logic [NUM_SUP*HI_W-1:0]  sup_hi,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic [BYTE_W-1:0]        s_data,
  input  logic                     s_sop,
  input  logic                     s_eop,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic [BYTE_W-1:0]        m_data,
  output logic                     m_sop,
  output logic                     m_eop
);
  localparam int OFF_W = $clog2(SA_OFS + SA_BYTES + 1);

  logic              fire;
  logic [ADDR_W-1:0] sel_addr;
  logic [OFF_W-1:0]  off;
  logic              win;
  logic              frm_en;
  logic [ADDR_W-1:0] frm_addr;

  assign fire    = s_valid && m_ready;
  assign s_ready = m_ready;
  assign m_valid = s_valid;
  assign m_sop   = s_sop;
  assign m_eop   = s_eop;

  sa_ins_select #(.NUM_SUP(NUM_SUP)) u_select (
    .sel(addr_sel), .prim_lo(prim_lo), .prim_hi(prim_hi),
    .sup_lo(sup_lo), .sup_hi(sup_hi), .addr_o(sel_addr)
  );

  sa_ins_track #(.OFF_W(OFF_W)) u_track (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sop(s_sop), .eop(s_eop),
    .en_i(ins_en), .addr_i(sel_addr), .off_o(off), .win_o(win),
    .frm_en_o(frm_en), .frm_addr_o(frm_addr)
  );

  sa_ins_replace #(.OFF_W(OFF_W)) u_replace (
    .din(s_data), .off(off), .win(win), .frm_en(frm_en),
    .frm_addr(frm_addr), .dout(m_data)
  );

  p_disabled_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !frm_en) |-> (m_data == s_data));
  p_outside_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !win) |-> (m_data == s_data));
  p_unused_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_sel inside {3'd1, 3'd2, 3'd3}) |-> (sel_addr == {prim_hi, prim_lo}));
endmodule

// File: tb/tx_srcaddr_ins_bench.sv
`timescale 1ns/1ps
module tx_srcaddr_ins_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ins_en = 1'b0;
  logic [2:0]   addr_sel = 3'd0;
  logic [31:0]  prim_lo = 32'h4433_2211;
  logic [15:0]  prim_hi = 16'h6655;
  logic [127:0] sup_lo = {32'hD3C3_B3A3, 32'hD2C2_B2A2, 32'hD1C1_B1A1, 32'hD0C0_B0A0};
  logic [63:0]  sup_hi = {16'hF3E3, 16'hF2E2, 16'hF1E1, 16'hF0E0};
  logic         s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0;
  logic [7:0]   s_data = 8'h00;
  logic         s_ready, m_valid, m_sop, m_eop;
  logic         m_ready = 1'b1;
  logic [7:0]   m_data;

  typedef struct packed { logic [7:0] data; logic sop; logic eop; logic [3:0] tag; } item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0, sent = 0, recv = 0;
  bit stall_mode = 1'b0, done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;  // 250 MHz

  tx_srcaddr_ins u_tx_srcaddr_ins (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .addr_sel(addr_sel),
    .prim_lo(prim_lo), .prim_hi(prim_hi), .sup_lo(sup_lo), .sup_hi(sup_hi),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sop(m_sop), .m_eop(m_eop)
  );

  function automatic string rname(input logic [3:0] t);
    case (t)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench view of the station table: codes 4..7 -> slot code-4, anything else primary
  function automatic logic [47:0] station(input logic [2:0] code);
    int n;
    if (code >= 3'd4) begin
      n = int'(code) - 4;
      return {sup_hi[16*n +: 16], sup_lo[32*n +: 32]};
    end
    return {prim_hi, prim_lo};
  endfunction

  // downstream ready: random when stalling, else always high
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  task automatic send_beat(input logic [7:0] d, input bit sop, input bit eop,
                           input logic [7:0] e, input logic [3:0] tag);
    item_t it;
    it.data = e; it.sop = sop; it.eop = eop; it.tag = tag;
    exp_q.push_back(it);
    s_valid = 1'b1; s_data = d; s_sop = sop; s_eop = eop;
    do @(posedge clk); while (!m_ready);
    #1;
    s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
    sent++;
  endtask

  task automatic send_frame(input int len, input bit en, input logic [2:0] code,
                            input bit mid, input int seed);
    logic [47:0] a;
    logic [31:0] keep_lo;
    logic [127:0] keep_sup;
    logic [7:0] d, e;
    logic [3:0] tag;
    keep_lo = prim_lo; keep_sup = sup_lo;
    ins_en = en; addr_sel = code;
    a = station(code);
    for (int k = 0; k < len; k++) begin
      d = 8'(k * 13 + seed);
      e = d;
      tag = en ? 4'd7 : 4'd2;             // R7 / R2
      if (en && k >= 6 && k < 12) begin
        e = 8'(a >> (8 * (k - 6)));        // R3 byte ordering
        if (mid)               tag = 4'd8; // R8
        else if (code == 3'd0) tag = 4'd4; // R4
        else if (code[2])      tag = 4'd5; // R5
        else                   tag = 4'd6; // R6
      end
      send_beat(d, k == 0, k == len - 1, e, tag);
      if (mid && k == 0) begin
        ins_en = ~en; addr_sel = code ^ 3'b100;
        prim_lo = ~prim_lo; sup_lo = ~sup_lo;
      end
    end
    prim_lo = keep_lo; sup_lo = keep_sup;
  endtask

  // monitor / scoreboard, sampled on the falling edge
  always @(negedge clk) begin
    item_t it;
    if (rst_n && !done) begin
      check(s_ready == m_ready && m_valid == s_valid && m_sop == s_sop && m_eop == s_eop,
            "R1", {m_valid, s_ready, m_sop, m_eop}, {s_valid, m_ready, s_sop, s_eop});
      if (m_valid && m_ready) begin
        recv++;
        if (exp_q.size() == 0) check(1'b0, "R9", 1, 0);
        else begin
          it = exp_q.pop_front();
          check(m_data == it.data && m_sop == it.sop && m_eop == it.eop, rname(it.tag),
                {m_sop, m_eop, m_data}, {it.sop, it.eop, it.data});
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(m_valid == 1'b0, "R10", m_valid, 0);   // reset state, nothing valid
    rst_n = 1'b1;
    @(posedge clk); #1;
    ins_en = 1'b1;
    for (int k = 0; k < 14; k++) send_beat(8'(k + 8'h80), 0, 0, 8'(k + 8'h80), 4'd10);  // R10 orphan beats
    for (int c = 0; c < 8; c++) send_frame(16, 1'b1, 3'(c), 1'b0, c * 5);  // R4 R5 R6
    send_frame(20, 1'b0, 3'd5, 1'b0, 3);       // R2 disabled
    send_frame(12, 1'b1, 3'd6, 1'b0, 9);       // R3 exact field end
    send_frame(8, 1'b1, 3'd7, 1'b0, 11);       // frame ends in address field
    send_frame(1, 1'b1, 3'd4, 1'b0, 21);       // single-beat frame
    send_frame(14, 1'b1, 3'd0, 1'b0, 17);      // next frame starts clean
    for (int k = 0; k < 10; k++) send_beat(8'(k), 0, 0, 8'(k), 4'd10);  // R10 after end beat
    send_frame(18, 1'b1, 3'd4, 1'b1, 2);       // R8 mid-frame change
    send_frame(18, 1'b0, 3'd7, 1'b1, 4);       // R8 enable raised mid-frame
    stall_mode = 1'b1;                         // R9 random stalls
    for (int r = 0; r < 12; r++) send_frame(10 + r, r % 3 != 0, 3'(r), r == 5, r * 7);
    stall_mode = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);
    check(sent == recv, "R9", recv, sent);
    finish_run();
  end
endmodule